// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

The block collects a serial bit stream into a chain of shift stages on one clock and copies the whole chain into a separate holding register on a second clock. The parallel lines show the holding register only while the active-low output enable is low. While the enable is high they float, so several sources can share the same lines. Because the shift stages and the holding register have separate clocks, a new word can be shifted in while the previous word is still on the outputs.

The last shift stage is always driven on a serial output, so several blocks can be chained into one longer register. An active-low clear empties the shift stages at once. The holding register keeps its data through a clear, and the cleared value reaches the outputs only at the next storage clock. When the two clocks are tied together, the holding register always lags the shift stages by one pulse.

Top module: `latched_sipo`

## Requirements
- R1: On each rising edge of `shift_clk_i`, stage 0 loads `ser_i` and every stage k>0 loads the old value of stage k-1. Stage k appears on `par_o[k]`, so the first bit of an 8-bit burst ends on `par_o[7]`.
- R2: On a rising edge of `store_clk_i`, all shift stages are copied into the holding register in parallel. Between storage edges, `par_o` keeps its value while shifting continues.
- R3: When `rst_ni` is low, the holding register keeps its value. The cleared contents reach `par_o` only after the next storage edge.
- R4: A low `rst_ni` forces every shift stage to 0 at once, without a clock edge. Shift edges that occur while it is low have no effect.
- R5: While `oe_ni` is high, every `par_o` line is high impedance, so a pull-up on the line reads 1. While `oe_ni` is low, `par_o` drives the holding register.
- R6: `ser_o` always equals the last shift stage, whatever the state of `oe_ni`.
- R7: With `shift_clk_i` and `store_clk_i` tied together, the holding register after each pulse equals the shift contents from before that pulse.
- R8: When no rising edge occurs on `shift_clk_i`, changes on `ser_i` leave the shift stages unchanged.
- R9: When two blocks are chained (the `ser_o` of the first drives the `ser_i` of the second, with shared clocks), 16 shifts followed by one storage edge leave the first bit on `par_o[7]` of the second block. The full 16-bit word is split with its upper byte in the second block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift clock, rising edge |
| store_clk_i | input | 1 | Storage clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low clear of the shift stages only |
| ser_i | input | 1 | Serial data in |
| oe_ni | input | 1 | Active-low enable for the parallel outputs |
| par_o | output | W (8) | Tri-state parallel outputs from the holding register |
| ser_o | output | 1 | Last shift stage, used for chaining |

## Verification
The bench sweeps all 256 byte values shifted in MSB first. Before each storage edge it checks that the outputs still hold the previous byte, which catches a holding register wired as a plain pass-through or a shift chain in reversed order. It pulses the shift clock during a clear and checks that the outputs keep their old byte. It then releases the clear, pulses the storage clock and checks for zeros. This catches a clear that also resets the holding register, or one that lets a shift edge through. With the clocks tied, it checks that the outputs lag by one pulse, which a design sampling the post-shift value would miss. A pull-up on the parallel lines exposes an enable of the wrong polarity, and a two-block chain exposes a serial output taken from the wrong stage.

// File: rtl/lsipo_pkg.sv
package lsipo_pkg;
  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/sipo_shift.sv
module sipo_shift #(
  parameter int unsigned W = lsipo_pkg::LANE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= {q_o[W-2:0], d_i};
  end
endmodule

// File: rtl/sipo_store.sv
module sipo_store #(
  parameter int unsigned W = lsipo_pkg::LANE_W
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // no reset: the clear deliberately does not reach this register
  always_ff @(posedge clk_i) q_o <= d_i;
endmodule

// File: rtl/sipo_tri_out.sv
module sipo_tri_out #(
  parameter int unsigned W = lsipo_pkg::LANE_W
) (
  input  logic         oe_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] pad_o
);
  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pad_o[i] = oe_ni ? 1'bz : d_i[i];
  end
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo #(
  parameter int unsigned W = lsipo_pkg::LANE_W
) (
  input  logic         shift_clk_i,
  input  logic         store_clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  input  logic         oe_ni,
  output logic [W-1:0] par_o,
  output logic         ser_o
);
  logic [W-1:0] sh_q;
  logic [W-1:0] st_q;

  sipo_shift #(.W(W)) u_shift (
    .clk_i (shift_clk_i),
    .rst_ni(rst_ni),
    .d_i   (ser_i),
    .q_o   (sh_q)
  );

  sipo_store #(.W(W)) u_store (
    .clk_i(store_clk_i),
    .d_i  (sh_q),
    .q_o  (st_q)
  );

  sipo_tri_out #(.W(W)) u_out (
    .oe_ni(oe_ni),
    .d_i  (st_q),
    .pad_o(par_o)
  );

  // cascade tap is taken ahead of the holding register and the enable
  assign ser_o = sh_q[W-1];
endmodule

// File: rtl/sipo_chk.sv
module sipo_chk #(
  parameter int unsigned W = 8
) (
  input logic         shift_clk_i,
  input logic         rst_ni,
  input logic         ser_i,
  input logic         oe_ni,
  input logic [W-1:0] par_o,
  input logic         ser_o,
  input logic [W-1:0] sh_q,
  input logic [W-1:0] st_q
);
  // R1
  shift_step_chk: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (sh_q[W-1:1] == $past(sh_q[W-2:0])) && (sh_q[0] == $past(ser_i)));

  // R4
  clear_zero_chk: assert property (@(negedge shift_clk_i)
    !rst_ni |-> sh_q == '0);

  // R3
  clear_keeps_store_chk: assert property (@(negedge shift_clk_i)
    (!rst_ni && $past(!rst_ni)) |-> $stable(st_q));

  // R5
  oe_drive_chk: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    !oe_ni |-> par_o == st_q);

  // R6
  ser_tap_chk: assert property (@(negedge shift_clk_i) disable iff (!rst_ni)
    ser_o == sh_q[W-1]);
endmodule

bind latched_sipo sipo_chk #(.W(W)) u_chk (
  .shift_clk_i(shift_clk_i),
  .rst_ni     (rst_ni),
  .ser_i      (ser_i),
  .oe_ni      (oe_ni),
  .par_o      (par_o),
  .ser_o      (ser_o),
  .sh_q       (sh_q),
  .st_q       (st_q)
);

// File: tb/sim_latched_sipo.sv
`timescale 1ns/1ps
module sim_latched_sipo;
  localparam real PERIOD = 5.0; // 200 MHz
  localparam int  W = 8;

  logic sclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, ser = 1'b0, oe_n = 1'b0;
  wire [W-1:0] par0, par1;
  wire         so0, so1;
  int checks = 0, errors = 0;

  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup pu0 (par0[i]);
    pullup pu1 (par1[i]);
  end

  latched_sipo #(.W(W)) u0 (
    .shift_clk_i(sclk), .store_clk_i(rclk), .rst_ni(rst_n),
    .ser_i(ser), .oe_ni(oe_n), .par_o(par0), .ser_o(so0));

  latched_sipo #(.W(W)) u1 (
    .shift_clk_i(sclk), .store_clk_i(rclk), .rst_ni(rst_n),
    .ser_i(so0), .oe_ni(oe_n), .par_o(par1), .ser_o(so1));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser = b; #1;
    sclk = 1'b1; #(PERIOD/2);
    sclk = 1'b0; #(PERIOD/2 - 1);
  endtask

  task automatic store_pulse();
    rclk = 1'b1; #(PERIOD/2);
    rclk = 1'b0; #(PERIOD/2);
  endtask

  task automatic tied_pulse(input logic b);
    ser = b; #1;
    sclk = 1'b1; rclk = 1'b1; #(PERIOD/2);
    sclk = 1'b0; rclk = 1'b0; #(PERIOD/2 - 1);
  endtask

  task automatic shift_byte(input logic [W-1:0] v);
    for (int k = W-1; k >= 0; k--) shift_bit(v[k]);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    logic [W-1:0] m_sh, m_st;
    // reset phase: clear held across shift edges
    shift_bit(1'b1); shift_bit(1'b1);
    chk("R4 reset ser_o", {15'd0, so0}, 16'd0);
    rst_n = 1'b1; #1;
    store_pulse();
    chk("R4 reset par_o", {8'd0, par0}, 16'd0);

    // R1 R2 R6: full sweep of byte values, MSB first
    prev = '0;
    for (int v = 0; v < 256; v++) begin
      shift_byte(W'(v));
      chk("R2 hold before store", {8'd0, par0}, {8'd0, prev});
      chk("R6 ser_o tap", {15'd0, so0}, {15'd0, W'(v) >> (W-1)});
      store_pulse();
      chk("R1 R2 parallel byte", {8'd0, par0}, 16'(v));
      prev = W'(v);
    end

    // R8: toggle serial input with no shift edge
    shift_byte(8'h3C); store_pulse();
    for (int k = 0; k < 6; k++) begin ser = ~ser; #2; end
    store_pulse();
    chk("R8 no edge no change", {8'd0, par0}, 16'h003C);

    // R5: enable high floats the lines (pull-up reads ones), ser_o unaffected
    shift_byte(8'h81); store_pulse();
    oe_n = 1'b1; #2;
    chk("R5 disabled reads pull-up", {8'd0, par0}, 16'h00FF);
    chk("R6 ser_o with oe high", {15'd0, so0}, 16'd1);
    oe_n = 1'b0; #2;
    chk("R5 enabled drives", {8'd0, par0}, 16'h0081);
    shift_byte(8'h00); store_pulse();
    oe_n = 1'b1; #2;
    chk("R5 zero stored still floats", {8'd0, par0}, 16'h00FF);
    oe_n = 1'b0; #2;
    chk("R5 zero stored driven", {8'd0, par0}, 16'h0000);

    // R3 R4: clear leaves the holding register alone, overrides shifting
    shift_byte(8'hA5); store_pulse();
    rst_n = 1'b0; #1;
    chk("R4 async clear ser_o", {15'd0, so0}, 16'd0);
    shift_bit(1'b1); shift_bit(1'b1);
    chk("R3 store kept during clear", {8'd0, par0}, 16'h00A5);
    rst_n = 1'b1; #1;
    chk("R3 store kept after clear", {8'd0, par0}, 16'h00A5);
    store_pulse();
    chk("R3 R4 cleared value stored", {8'd0, par0}, 16'h0000);

    // R7: tied clocks, holding register lags by one pulse
    m_sh = '0; m_st = '0;
    for (int k = 0; k < 12; k++) begin
      logic b;
      b = logic'((k * 5 + 1) % 3 == 0);
      tied_pulse(b);
      m_st = m_sh;
      m_sh = {m_sh[W-2:0], b};
      chk("R7 tied lag", {8'd0, par0}, {8'd0, m_st});
    end

    // R9: two-block chain, 16 bits then one store
    foreach (prev[i]) begin end
    for (int t = 0; t < 4; t++) begin
      logic [15:0] w;
      w = (t == 0) ? 16'h8001 : (t == 1) ? 16'h1234 : (t == 2) ? 16'hFEDC : 16'h7F80;
      for (int k = 15; k >= 0; k--) shift_bit(w[k]);
      store_pulse();
      chk("R9 first bit on downstream MSB", {15'd0, par1[W-1]}, {15'd0, w[15]});
      chk("R9 chained word", {par1, par0}, w);
      chk("R9 downstream ser_o", {15'd0, so1}, {15'd0, w[15]});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule